// File: doc/BRIEF.md
# Receiver Status Blink Pattern Generator

This block turns a 2-bit navigation-state code from a satellite receiver into a one-second indicator waveform. The share of each second that the indicator is high tells the observer which state the receiver is in. The four levels are always low, a short pulse, a long pulse and always high. A second output is an active-low valid-fix level. The held state code is also returned on its own output field, so a register read path can report it.

Timing comes from a single system clock. A clock-enable prescaler divides it down to millisecond ticks, and a tick counter splits those ticks into periods. The incoming state code is captured only at the start of a period. Each period therefore always shows one complete pattern, even when the code changes partway through it.

Top module: `blink_pattern_gen`

## Requirements
- R1: A millisecond tick occurs once every CLK_HZ/TICK_HZ clocks, and one indicator period lasts PERIOD_MS ticks (1000 by default, so 1 Hz).
- R2: While the held code is 0 (receiver stopped or not tracking), `blink_o` stays low for the whole period.
- R3: While the held code is 1 (tracking, no pseudoranges), `blink_o` is high for the first SHORT_MS ticks (200) of the period and low for the rest.
- R4: While the held code is 2 (pseudoranges available, not navigating), `blink_o` is high for the first LONG_MS ticks (800) of the period and low for the rest.
- R5: While the held code is 3 (navigating with valid fix), `blink_o` stays high for the whole period.
- R6: `fix_n_o` is low exactly when the held code is 3 and high otherwise.
- R7: `nav_code_i` is sampled only on the clock edge that ends a period. A change at any other time has no effect on any output until the next period begins.
- R8: A synchronous active-low reset clears the tick and period counters and the held code. After reset `blink_o` is low, `fix_n_o` is high and `held_code_o` is 0 until the first period boundary.
- R9: `held_code_o` always shows the code that is currently being displayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| nav_code_i | input | 2 | Receiver navigation-state code (0..3) |
| blink_o | output | 1 | Indicator waveform |
| fix_n_o | output | 1 | Valid-fix level, low when a fix is held |
| held_code_o | output | 2 | Code currently displayed |

## Verification
The bench changes the state code mid-period, both right after a boundary and late in a period. A design that sampled the input continuously would cut a pulse short or lengthen it, and the per-clock comparison would catch that at once. High time is totalled over every completed period and compared with 0, 200, 800 or 1000 ticks, so an off-by-one in a threshold compare or in the counter wrap shows up as a wrong total. A reset asserted mid-period checks that the output drops and stays low for a whole period, instead of resuming the old pattern or taking the new code early.

// File: rtl/blink_pkg.sv
// Shared types for the blink pattern generator.
// Assumes the receiver drives a 2-bit code with the ordering below.
package blink_pkg;
    typedef enum logic [1:0] {
        NAV_IDLE  = 2'd0,   // stopped or not tracking
        NAV_ACQ   = 2'd1,   // tracking, no pseudoranges
        NAV_RANGE = 2'd2,   // pseudoranges, not navigating
        NAV_FIX   = 2'd3    // navigating, valid fix
    } nav_state_e;
endpackage

// File: rtl/blink_prescaler.sv
// Clock-enable prescaler: one-cycle tick every DIV clocks.
// Assumes DIV >= 1; with DIV == 1 the tick is held high.
module blink_prescaler #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_cnt;

    assign tick_o = (pre_cnt == LAST);

    // Count clocks and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_cnt <= '0;
        else if (tick_o) pre_cnt <= '0;
        else             pre_cnt <= pre_cnt + 1'b1;
    end

    p_pre_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_cnt) < DIV);

    generate
        if (DIV > 1) begin : g_spacing
            p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/blink_period_ctr.sv
// Counts ticks within one indicator period and flags the boundary.
// Assumes tick_i is a one-cycle enable; boundary_o marks the last tick.
module blink_period_ctr #(
    parameter int PERIOD = 1000,
    localparam int TW = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [TW-1:0] cnt_o,
    output logic          boundary_o
);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    assign boundary_o = tick_i && (cnt_o == LAST);

    // Advance on each tick, restart at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_o <= '0;
        else if (boundary_o) cnt_o <= '0;
        else if (tick_i)     cnt_o <= cnt_o + 1'b1;
    end

    p_ms_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_o) < PERIOD);
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> (cnt_o == '0));
endmodule

// File: rtl/blink_pattern.sv
// Holds the state code for a period and decodes the indicator level.
// Assumes cnt_i counts 0..PERIOD-1 and boundary_i marks the period end.
module blink_pattern
    import blink_pkg::*;
#(
    parameter int PERIOD   = 1000,
    parameter int SHORT_MS = 200,
    parameter int LONG_MS  = 800,
    localparam int TW = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary_i,
    input  logic [TW-1:0] cnt_i,
    input  logic [1:0]    code_i,
    output logic          blink_o,
    output logic          fix_n_o,
    output nav_state_e    held_o
);
    localparam logic [TW-1:0] T_SHORT = TW'(SHORT_MS);
    localparam logic [TW-1:0] T_LONG  = TW'(LONG_MS);
    localparam logic [TW-1:0] T_FULL  = TW'(PERIOD);

    nav_state_e    held_q;
    logic [TW-1:0] thresh;

    // Capture the incoming code only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          held_q <= NAV_IDLE;
        else if (boundary_i) held_q <= nav_state_e'(code_i);
    end

    // Map the held state to its high time in ticks.
    always_comb begin
        unique case (held_q)
            NAV_IDLE:  thresh = '0;
            NAV_ACQ:   thresh = T_SHORT;
            NAV_RANGE: thresh = T_LONG;
            default:   thresh = T_FULL;
        endcase
    end

    assign blink_o = (cnt_i < thresh);
    assign fix_n_o = (held_q != NAV_FIX);
    assign held_o  = held_q;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> $stable(held_q));
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == NAV_IDLE) |-> !blink_o);
    p_short_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == NAV_ACQ && cnt_i >= T_SHORT) |-> !blink_o);
    p_long_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == NAV_RANGE && cnt_i < T_LONG) |-> blink_o);
    p_fix_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == NAV_FIX) |-> blink_o);
    p_fix_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fix_n_o |-> blink_o);
endmodule

// File: rtl/blink_pattern_gen.sv
// Top: receiver status blink pattern generator.
// Assumes CLK_HZ is a multiple of TICK_HZ; nav_code_i is synchronous to clk.
module blink_pattern_gen
    import blink_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int TICK_HZ   = 1000,
    parameter int PERIOD_MS = 1000,
    parameter int SHORT_MS  = 200,
    parameter int LONG_MS   = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] nav_code_i,
    output logic       blink_o,
    output logic       fix_n_o,
    output logic [1:0] held_code_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int TW  = $clog2(PERIOD_MS + 1);

    logic          tick;
    logic          boundary;
    logic [TW-1:0] ms_cnt;
    nav_state_e    held;

    blink_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    blink_period_ctr #(.PERIOD(PERIOD_MS)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .cnt_o(ms_cnt), .boundary_o(boundary)
    );

    blink_pattern #(.PERIOD(PERIOD_MS), .SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_pat (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .cnt_i(ms_cnt),
        .code_i(nav_code_i), .blink_o(blink_o), .fix_n_o(fix_n_o), .held_o(held)
    );

    assign held_code_o = held;

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (held_code_o == 2'd0 && !blink_o && fix_n_o));
    p_code_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(held_code_o) |-> ($past(ms_cnt) == TW'(PERIOD_MS - 1)));
endmodule

// File: tb/sim_blink_pattern_gen.sv
// Bench: behavioural per-clock reference model compared on every falling edge.
module sim_blink_pattern_gen;
    localparam int CLK_HZ = 2000;
    localparam int TICK_HZ = 1000;
    localparam int PER = 1000;
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] nav_code = 2'd0;
    logic       blink, fix_n;
    logic [1:0] held_code;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_pre = 0, m_ms = 0, m_held = 0;
    bit wrap_ev = 0;
    int prev_held = 0;
    int acc = 0;

    always #2 clk = ~clk;

    blink_pattern_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .nav_code_i(nav_code),
        .blink_o(blink), .fix_n_o(fix_n), .held_code_o(held_code)
    );

    function automatic int high_ticks(int h);
        case (h)
            0: return 0;
            1: return 200;
            2: return 800;
            default: return PER;
        endcase
    endfunction

    function automatic string tag_for(int h);
        case (h)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // model update on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pre = 0; m_ms = 0; m_held = 0; wrap_ev = 0; acc = 0;
        end else if (m_pre == DIV - 1) begin
            m_pre = 0;
            if (m_ms == PER - 1) begin
                m_ms = 0; prev_held = m_held; m_held = nav_code; wrap_ev = 1;
            end else m_ms++;
        end else m_pre++;
    end

    // compare outputs on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(held_code == 2'(m_held), "R7 R9", held_code, m_held, "held code");
            check(blink == (m_ms < high_ticks(m_held)), tag_for(m_held), blink,
                  (m_ms < high_ticks(m_held)), "blink level");
            check(fix_n == (m_held != 3), "R6", fix_n, (m_held != 3), "fix flag");
            if (wrap_ev) begin
                check(acc == DIV * high_ticks(prev_held), "R1", acc,
                      DIV * high_ticks(prev_held), "high clocks in period");
                acc = 0; wrap_ev = 0;
            end
            if (blink) acc++;
        end
    end

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one period with two input changes at chosen points
    task automatic period(logic [1:0] a, logic [1:0] b, int t_a, int t_b);
        wait_clk(t_a); nav_code = a;
        wait_clk(t_b - t_a); nav_code = b;
        wait_clk(PER * DIV - t_b);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(blink == 1'b0, "R8", blink, 0, "blink after reset");
        check(fix_n == 1'b1, "R8", fix_n, 1, "fix flag after reset");
        check(held_code == 2'd0, "R8", held_code, 0, "held after reset");
        nav_code = 2'd3;
        wait_clk(PER * DIV - 10);
        // still low: code 3 not taken before the boundary (R7, R8)
        check(blink == 1'b0, "R8", blink, 0, "blink before first boundary");
        wait_clk(20);
        check(blink == 1'b1 && held_code == 2'd3, "R5", blink, 1, "fix state shown");
        check(fix_n == 1'b0, "R6", fix_n, 0, "fix flag low");
        period(2'd1, 2'd1, 100, 1500);
        period(2'd2, 2'd0, 10, 1000);
        period(2'd3, 2'd2, 5, 1990);
        period(2'd1, 2'd2, 700, 1200);
        period(2'd0, 2'd3, 50, 1800);
        period(2'd0, 2'd1, 300, 1999);
        period(2'd2, 2'd2, 1, 2);
        period(2'd3, 2'd3, 1, 2);
        // mid-period reset (R8)
        wait_clk(700);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        nav_code = 2'd1;
        @(negedge clk);
        check(blink == 1'b0 && held_code == 2'd0, "R8", blink, 0, "blink after mid reset");
        wait_clk(PER * DIV + 10);
        check(held_code == 2'd1, "R7", held_code, 1, "code after reset period");
        period(2'd2, 2'd0, 400, 1000);
        wait_clk(PER * DIV + 10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            errors++;
            vectors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule